// File: doc/BRIEF.md
# Two-Port Serial Management Frame Engine

This block is the master side of a two-wire serial management link that reads and writes the 32 registers of a PHY using clause-22 style frames. The PHY can sit on either of two data lines: an internal one or an external one. They share one management clock, and each line has its own output, output enable and input. Right after reset the engine probes both lines to find which one has a pull-up, and so which port has a PHY. From then on every frame goes to that port, and carries the fixed PHY address that belongs to it.

A request is a single-cycle strobe with an operation flag, a 5-bit register number and 16 bits of write data. The engine marks itself busy. It sends a run of idle ones, then the frame. For a read it releases the line, skips the turnaround, shifts in 16 data bits and then clocks three trailing bit times. A one-cycle done pulse ends every transfer, and for a read the collected word appears on the read data output at that pulse. The speed of the management clock is set at run time by the number of system clocks in each half of a bit.

Top module: `mdio_mgmt_engine`

## Requirements
- R1: The engine comes out of reset busy and in its probe phase. For one bit time, both data lines are driven to 1 with both output enables set.
- R2: After that bit time both lines are released for one more bit time, and then sampled. If the external line reads 1, the external port is selected (`port_ext`=1). Otherwise, if the internal line reads 1, the internal port is selected (`port_ext`=0). The external line wins when both read 1.
- R3: If neither line reads 1, `port_err` is set and busy falls. Until the next reset every request is ignored: busy stays 0 and the management clock does not toggle.
- R4: Each bit is one low phase followed by one high phase of the management clock. Each phase lasts `half_div` system clocks, and a value of 0 counts as 1. Every frame begins with 32 bits of 1 on the selected line with its output enable set.
- R5: A write (`req_write`=1) drives 64 bits, MSB of each field first, in this order: 32 ones, start 0,1, opcode 0,1, the 5-bit PHY address, the 5-bit register number, turnaround 1,0, and the 16 data bits. The clock rises 64 times.
- R6: A read (`req_write`=0) drives 46 bits in this order: 32 ones, start 0,1, opcode 1,0, PHY address and register number. It then keeps the output enable low for 21 more bit times, so the clock rises 67 times in all.
- R7: Of the 21 released read bits, the first two are discarded, the next 16 form the read word (MSB first), and the last three are ignored. The word is presented on `rd_data` in the cycle `done` is high.
- R8: On the external port each read bit is sampled in the last system clock before the clock rises. On the internal port it is sampled in the last system clock of the high phase.
- R9: The PHY address field is `EXT_PHY_ADDR` (default 5'h00) on the external port and `INT_PHY_ADDR` (default 5'h01) on the internal port.
- R10: `busy` is high from the cycle after a request is accepted until `done`. `done` is high for exactly one cycle, with `busy` already low. A request presented while busy is ignored.
- R11: During a frame, the output enable of the port that was not selected stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; starts the port probe |
| half_div | input | DIV_W | System clocks per management clock phase (0 acts as 1) |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write frame, 0 = read frame |
| req_reg | input | 5 | PHY register number |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Probe or transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rd_data | output | 16 | Word from the last read |
| port_ext | output | 1 | 1 = external port selected |
| port_err | output | 1 | Probe found no port |
| mdc | output | 1 | Management clock |
| ext_mdio_o | output | 1 | External data line output value |
| ext_mdio_oe | output | 1 | External data line output enable |
| ext_mdio_i | input | 1 | External data line input |
| int_mdio_o | output | 1 | Internal data line output value |
| int_mdio_oe | output | 1 | Internal data line output enable |
| int_mdio_i | input | 1 | Internal data line input |

## Verification
Probing is tried with pull-ups on both lines, on the internal line only, and on neither line. These three cases separate the priority rule from the error path. Directed frames with all-ones and single-edge data words, divider values 0 and 1, and random registers, data and dividers on both ports show whether field order, PHY address and phase length are right. The bench PHY model presents each read bit in the phase its port samples and drives the inverted value in the other phase. A read sampled at the wrong point therefore returns inverted data and cannot pass. A request strobed in the middle of a frame tells whether requests are really ignored while busy.

// File: rtl/mdio_fe_pkg.sv
// Package: frame geometry and state encoding shared by the management
// frame engine modules. Assumes clause-22 style frames of fixed length.
package mdio_fe_pkg;
    localparam int PRE_BITS  = 32;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 16;
    localparam int TA_BITS   = 2;
    localparam int TAIL_BITS = 3;
    localparam int HDR_BITS  = 4 + 2 * ADDR_W;
    localparam int WR_BITS   = PRE_BITS + HDR_BITS + TA_BITS + DATA_W;
    localparam int RD_DRIVE  = PRE_BITS + HDR_BITS;
    localparam int RD_BITS   = RD_DRIVE + TA_BITS + DATA_W + TAIL_BITS;

    localparam logic [1:0] SOF_CODE = 2'b01;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] TA_WRITE = 2'b10;

    typedef enum logic [2:0] {
        ST_PROBE_DRV,
        ST_PROBE_REL,
        ST_IDLE,
        ST_SHIFT,
        ST_FAULT
    } seq_state_e;
endpackage

// File: rtl/mdio_bit_timer.sv
// Bit timer: while run is high, produces the management clock as a low
// phase then a high phase, each half_div system clocks long (0 acts as 1).
// Strobes low_end in the last cycle of a low phase and bit_end in the last
// cycle of a high phase. Assumes half_div is stable while run is high.
module mdio_bit_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             mdc,
    output logic             low_end,
    output logic             bit_end
);
    logic [DIV_W-1:0] cnt;
    logic             phase_hi;
    logic [DIV_W-1:0] lim_m1;
    logic             wrap;

    // Last count value of a phase, with 0 treated as 1.
    always_comb lim_m1 = (half_div == '0) ? '0 : half_div - 1'b1;

    assign wrap    = run && (cnt == lim_m1);
    assign low_end = wrap && !phase_hi;
    assign bit_end = wrap && phase_hi;
    assign mdc     = phase_hi;

    // Phase counter and clock phase; parked low while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt      <= '0;
            phase_hi <= 1'b0;
        end else if (wrap) begin
            cnt      <= '0;
            phase_hi <= ~phase_hi;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    a_r4_parked_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);
    a_r4_rise_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> $past(low_end));
endmodule

// File: rtl/mdio_frame_seq.sv
// Frame sequencer: probes the two data lines after reset, then accepts
// requests, shifts out a preamble plus frame MSB first, and collects read
// data at the sample point of the selected port. Assumes the bit timer
// strobes arrive only while run is high.
module mdio_frame_seq
    import mdio_fe_pkg::*;
#(
    parameter logic [ADDR_W-1:0] EXT_PHY_ADDR = 5'h00,
    parameter logic [ADDR_W-1:0] INT_PHY_ADDR = 5'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              low_end,
    input  logic              bit_end,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ext_in,
    input  logic              int_in,
    output logic              run,
    output logic              probe_drive,
    output logic              drv_o,
    output logic              drv_oe,
    output logic              sel_ext,
    output logic              port_err,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data
);
    localparam int BIT_W = $clog2(RD_BITS + 1);
    localparam logic [BIT_W-1:0] WR_LAST = BIT_W'(WR_BITS - 1);
    localparam logic [BIT_W-1:0] RD_LAST = BIT_W'(RD_BITS - 1);
    localparam logic [BIT_W-1:0] WR_DRV  = BIT_W'(WR_BITS);
    localparam logic [BIT_W-1:0] RD_DRV  = BIT_W'(RD_DRIVE);
    localparam logic [BIT_W-1:0] WIN_LO  = BIT_W'(RD_DRIVE + TA_BITS);
    localparam logic [BIT_W-1:0] WIN_HI  = BIT_W'(RD_DRIVE + TA_BITS + DATA_W);

    seq_state_e         st;
    logic [WR_BITS-1:0] shreg;
    logic [BIT_W-1:0]   bit_idx;
    logic               is_wr;
    logic [DATA_W-1:0]  cap;
    logic               din;
    logic               samp_tick;
    logic               in_win;
    logic [ADDR_W-1:0]  phy_addr;

    assign din       = sel_ext ? ext_in : int_in;
    assign samp_tick = sel_ext ? low_end : bit_end;
    assign in_win    = (bit_idx >= WIN_LO) && (bit_idx < WIN_HI);
    assign phy_addr  = sel_ext ? EXT_PHY_ADDR : INT_PHY_ADDR;

    assign run         = (st == ST_PROBE_DRV) || (st == ST_PROBE_REL) || (st == ST_SHIFT);
    assign busy        = run;
    assign probe_drive = (st == ST_PROBE_DRV);
    assign drv_oe      = (st == ST_SHIFT) && (bit_idx < (is_wr ? WR_DRV : RD_DRV));
    assign drv_o       = shreg[WR_BITS-1];

    // Probe, request acceptance, bit shifting and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_PROBE_DRV;
            sel_ext  <= 1'b0;
            port_err <= 1'b0;
            done     <= 1'b0;
            rd_data  <= '0;
            shreg    <= '0;
            bit_idx  <= '0;
            is_wr    <= 1'b0;
            cap      <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_PROBE_DRV: if (bit_end) st <= ST_PROBE_REL;
                ST_PROBE_REL: begin
                    if (bit_end) begin
                        if (ext_in) begin
                            sel_ext <= 1'b1;
                            st      <= ST_IDLE;
                        end else if (int_in) begin
                            sel_ext <= 1'b0;
                            st      <= ST_IDLE;
                        end else begin
                            port_err <= 1'b1;
                            st       <= ST_FAULT;
                        end
                    end
                end
                ST_IDLE: begin
                    if (req_valid) begin
                        st      <= ST_SHIFT;
                        is_wr   <= req_write;
                        bit_idx <= '0;
                        shreg   <= {{PRE_BITS{1'b1}}, SOF_CODE,
                                    req_write ? OP_WRITE : OP_READ,
                                    phy_addr, req_reg,
                                    req_write ? TA_WRITE : 2'b11,
                                    req_write ? req_wdata : {DATA_W{1'b1}}};
                    end
                end
                ST_SHIFT: begin
                    if (samp_tick && in_win) cap <= {cap[DATA_W-2:0], din};
                    if (bit_end) begin
                        shreg   <= {shreg[WR_BITS-2:0], 1'b1};
                        bit_idx <= bit_idx + 1'b1;
                        if (bit_idx == (is_wr ? WR_LAST : RD_LAST)) begin
                            st   <= ST_IDLE;
                            done <= 1'b1;
                            if (!is_wr) rd_data <= cap;
                        end
                    end
                end
                default: st <= ST_FAULT;
            endcase
        end
    end

    a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r3_fault_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FAULT) |=> (st == ST_FAULT) && !busy);
endmodule

// File: rtl/mdio_port_mux.sv
// Port steering: during the probe both lines are driven high; otherwise
// the frame output goes only to the selected port. Assumes sel_ext is
// stable for the whole of a frame.
module mdio_port_mux (
    input  logic clk,
    input  logic rst_n,
    input  logic probe_drive,
    input  logic sel_ext,
    input  logic drv_o,
    input  logic drv_oe,
    output logic ext_o,
    output logic ext_oe,
    output logic int_o,
    output logic int_oe
);
    // Route the frame driver to one port, or both during the probe.
    always_comb begin
        ext_oe = probe_drive || (sel_ext && drv_oe);
        int_oe = probe_drive || (!sel_ext && drv_oe);
        ext_o  = probe_drive || drv_o;
        int_o  = probe_drive || drv_o;
    end

    a_r11_one_port: assert property (@(posedge clk) disable iff (!rst_n)
        !probe_drive |-> !(ext_oe && int_oe));
endmodule

// File: rtl/mdio_mgmt_engine.sv
// Top of the two-port serial management frame engine. Probes for the PHY
// port after reset, then runs read and write frames on request. Assumes
// half_div is held stable while busy and requests are single-cycle strobes.
module mdio_mgmt_engine
    import mdio_fe_pkg::*;
#(
    parameter int                DIV_W        = 8,
    parameter logic [ADDR_W-1:0] EXT_PHY_ADDR = 5'h00,
    parameter logic [ADDR_W-1:0] INT_PHY_ADDR = 5'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              port_ext,
    output logic              port_err,
    output logic              mdc,
    output logic              ext_mdio_o,
    output logic              ext_mdio_oe,
    input  logic              ext_mdio_i,
    output logic              int_mdio_o,
    output logic              int_mdio_oe,
    input  logic              int_mdio_i
);
    logic run, low_end, bit_end, probe_drive, drv_o, drv_oe;

    mdio_bit_timer #(.DIV_W(DIV_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .run(run), .half_div(half_div),
        .mdc(mdc), .low_end(low_end), .bit_end(bit_end)
    );

    mdio_frame_seq #(.EXT_PHY_ADDR(EXT_PHY_ADDR), .INT_PHY_ADDR(INT_PHY_ADDR)) seq_i (
        .clk(clk), .rst_n(rst_n), .low_end(low_end), .bit_end(bit_end),
        .req_valid(req_valid), .req_write(req_write), .req_reg(req_reg),
        .req_wdata(req_wdata), .ext_in(ext_mdio_i), .int_in(int_mdio_i),
        .run(run), .probe_drive(probe_drive), .drv_o(drv_o), .drv_oe(drv_oe),
        .sel_ext(port_ext), .port_err(port_err), .busy(busy), .done(done),
        .rd_data(rd_data)
    );

    mdio_port_mux mux_i (
        .clk(clk), .rst_n(rst_n), .probe_drive(probe_drive), .sel_ext(port_ext),
        .drv_o(drv_o), .drv_oe(drv_oe),
        .ext_o(ext_mdio_o), .ext_oe(ext_mdio_oe),
        .int_o(int_mdio_o), .int_oe(int_mdio_oe)
    );

    a_r10_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));
endmodule

// File: tb/mdio_mgmt_engine_tb_top.sv
module mdio_mgmt_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] half_div = 8'd2;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [4:0] req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic busy, done, port_ext, port_err, mdc;
    logic [15:0] rd_data;
    logic ext_mdio_o, ext_mdio_oe, ext_mdio_i, int_mdio_o, int_mdio_oe, int_mdio_i;

    // Bench-side line model.
    logic pull_ext = 1'b1, pull_int = 1'b1;
    logic exp_ext = 1'b1;
    logic phy_en = 1'b0, phy_v = 1'b1, cur_d = 1'b0;
    logic [15:0] rd_val = '0;

    assign ext_mdio_i = ext_mdio_oe ? ext_mdio_o : ((phy_en && exp_ext) ? phy_v : pull_ext);
    assign int_mdio_i = int_mdio_oe ? int_mdio_o : ((phy_en && !exp_ext) ? phy_v : pull_int);

    mdio_mgmt_engine dut_i (
        .clk(clk), .rst_n(rst_n), .half_div(half_div), .req_valid(req_valid),
        .req_write(req_write), .req_reg(req_reg), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data), .port_ext(port_ext),
        .port_err(port_err), .mdc(mdc), .ext_mdio_o(ext_mdio_o),
        .ext_mdio_oe(ext_mdio_oe), .ext_mdio_i(ext_mdio_i),
        .int_mdio_o(int_mdio_o), .int_mdio_oe(int_mdio_oe), .int_mdio_i(int_mdio_i)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_vec = 0, n_bad = 0;
    int cyc = 0, rises = 0, last_rise = 0, gap_exp = 2, gap_bad = 0, other_bad = 0;
    bit frame_on = 1'b0, mdc_prev = 1'b0;
    logic cap_oe [0:79];
    logic cap_o  [0:79];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] frame_vec(bit wr, logic [4:0] pa, logic [4:0] ra, logic [15:0] wd);
        return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), pa, ra,
                (wr ? 2'b10 : 2'b11), (wr ? wd : 16'hFFFF)};
    endfunction

    function automatic logic phy_bit(int idx);
        if (idx < 48) return 1'b0;
        return rd_val[63 - idx];
    endfunction

    // Line monitor and PHY model, away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (mdc && !mdc_prev) begin
            if (rises < 80) begin
                cap_oe[rises] = exp_ext ? ext_mdio_oe : int_mdio_oe;
                cap_o[rises]  = exp_ext ? ext_mdio_o : int_mdio_o;
            end
            if (rises > 0 && (cyc - last_rise) != gap_exp) gap_bad++;
            last_rise = cyc;
            rises++;
            if (phy_en) phy_v = exp_ext ? ~cur_d : cur_d;
        end
        if (!mdc && mdc_prev) begin
            if (rises >= 46 && rises < 64) begin
                phy_en = 1'b1;
                cur_d  = phy_bit(rises);
                phy_v  = exp_ext ? cur_d : ~cur_d;
            end else begin
                phy_en = 1'b0;
            end
        end
        if (frame_on && (exp_ext ? int_mdio_oe : ext_mdio_oe)) other_bad++;
        mdc_prev = mdc;
    end

    // Watchdog: a hang is a failed check and still reaches the summary.
    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL R10 watchdog actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    task automatic do_reset(input bit pe, input bit pi);
        int t;
        pull_ext = pe; pull_int = pi; half_div = 8'd2;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b1, "R1 busy in probe", busy, 1);
        chk(ext_mdio_oe && int_mdio_oe && ext_mdio_o && int_mdio_o,
            "R1 both lines driven high", {ext_mdio_oe, int_mdio_oe, ext_mdio_o, int_mdio_o}, 4'hF);
        t = 0;
        while (busy && t < 200) begin @(negedge clk); t++; end
        chk(busy === 1'b0, "R2 probe finishes", busy, 0);
    endtask

    task automatic do_frame(input bit wr, input logic [4:0] ra, input logic [15:0] wd,
                            input logic [15:0] rv, input logic [7:0] dv, input bit poke);
        logic [63:0] vec;
        int n_exp, drv, mism, amis, pmis, t;
        logic [4:0] pa;
        pa = exp_ext ? 5'h00 : 5'h01;
        vec = frame_vec(wr, pa, ra, wd);
        n_exp = wr ? 64 : 67;
        drv = wr ? 64 : 46;
        half_div = dv; rd_val = rv;
        gap_exp = 2 * ((dv == 0) ? 1 : int'(dv));
        rises = 0; gap_bad = 0; other_bad = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_reg = ra; req_wdata = wd;
        frame_on = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy === 1'b1, "R10 busy after accept", busy, 1);
        if (poke) begin
            repeat (40) @(negedge clk);
            req_valid = 1'b1; req_write = ~wr; req_reg = ~ra; req_wdata = ~wd;
            @(negedge clk);
            req_valid = 1'b0;
        end
        t = 0;
        while (!done && t < 5000) begin @(negedge clk); t++; end
        chk(done === 1'b1, "R10 done seen", done, 1);
        chk(busy === 1'b0, "R10 busy low at done", busy, 0);
        if (!wr) chk(rd_data === rv, exp_ext ? "R7 R8 read word external" : "R7 R8 read word internal", rd_data, rv);
        frame_on = 1'b0;
        @(negedge clk);
        chk(done === 1'b0, "R10 done one cycle", done, 0);
        chk(rises == n_exp, wr ? "R5 clock rises" : "R6 clock rises", rises, n_exp);
        mism = 0; amis = 0; pmis = 0;
        for (int k = 0; k < n_exp && k < 80; k++) begin
            if (k < drv) begin
                if (cap_oe[k] !== 1'b1 || cap_o[k] !== vec[63 - k]) begin
                    mism++;
                    if (k < 32) pmis++;
                    if (k >= 36 && k < 41) amis++;
                end
            end else if (cap_oe[k] !== 1'b0) begin
                mism++;
            end
        end
        chk(mism == 0, wr ? "R5 write frame bits" : "R6 read frame bits", mism, 0);
        chk(amis == 0, "R9 PHY address field", amis, 0);
        chk(pmis == 0 && gap_bad == 0, "R4 preamble and phase length", pmis + gap_bad, 0);
        chk(other_bad == 0, "R11 unselected port quiet", other_bad, 0);
        if (poke) begin
            repeat (30) @(negedge clk);
            chk(busy === 1'b0 && rises == n_exp, "R10 request while busy ignored", rises, n_exp);
        end
    endtask

    task automatic rand_frames(input int n);
        for (int i = 0; i < n; i++) begin
            do_frame(1'($urandom_range(0, 1)), 5'($urandom), 16'($urandom),
                     16'($urandom), 8'($urandom_range(1, 4)), 1'b0);
        end
    endtask

    initial begin
        int r0;
        r0 = $urandom(32'd20240611);
        // Both pull-ups present: external wins.
        exp_ext = 1'b1;
        do_reset(1'b1, 1'b1);
        chk(port_ext === 1'b1 && port_err === 1'b0, "R2 external preferred", {port_ext, port_err}, 2'b10);
        do_frame(1'b1, 5'h1F, 16'hFFFF, 16'h0, 8'd1, 1'b0);
        do_frame(1'b0, 5'h01, 16'h0, 16'h8001, 8'd0, 1'b0);
        do_frame(1'b0, 5'h10, 16'h0, 16'h7FFE, 8'd3, 1'b0);
        do_frame(1'b1, 5'h00, 16'h0001, 16'h0, 8'd2, 1'b1);
        rand_frames(6);
        // Internal pull-up only.
        exp_ext = 1'b0;
        do_reset(1'b0, 1'b1);
        chk(port_ext === 1'b0 && port_err === 1'b0, "R2 internal selected", {port_ext, port_err}, 2'b00);
        do_frame(1'b0, 5'h05, 16'h0, 16'hA5C3, 8'd1, 1'b0);
        do_frame(1'b1, 5'h0A, 16'h8000, 16'h0, 8'd0, 1'b0);
        rand_frames(5);
        // No pull-up anywhere.
        exp_ext = 1'b1;
        do_reset(1'b0, 1'b0);
        chk(port_err === 1'b1, "R3 probe error flagged", port_err, 1);
        rises = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_reg = 5'h03;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (50) @(negedge clk);
        chk(busy === 1'b0 && rises == 0, "R3 requests ignored after error", rises, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule